// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

This block controls a port of general-purpose pins, eight by default. Each pin has its own bits for direction, output level, reduced drive, pull enable, polarity and interrupt enable. Software sets these bits over a simple synchronous register bus. The block turns them into pad-control signals: output enable, output value, reduced-drive select, pull-up enable and pull-down enable.

The pad inputs pass through a two-stage synchronizer. The synchronized level is compared with its value one clock earlier to find edges. An edge of the kind chosen by a pin's polarity bit sets that pin's sticky flag, provided the pin's interrupt is enabled. This happens whether the pin is an input or an output. The polarity bit does two jobs: it picks the edge, and it picks the direction of the pull device. The flags that are enabled are combined into one interrupt request.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register and flag reads 0. No pad is driven, no pull device is enabled and `irq` is low.
- R2: When a pin's direction bit is 0, its `pad_oe`, `pad_out` and `pad_rdrv` bits are 0, whatever the level and reduced-drive bits hold.
- R3: When a pin is an input with pull enable 1, polarity 0 turns on the pull-up and polarity 1 turns on the pull-down. With pull enable 0, neither pull device is on. Both are never on at once.
- R4: When a pin's direction bit is 1, `pad_oe` is 1 and `pad_out` equals the level bit. Both pull devices are off, whatever the pull-enable bit holds.
- R5: On an output pin, `pad_rdrv` equals the reduced-drive bit: 1 selects reduced drive and 0 selects full drive.
- R6: With interrupt enable 1, polarity 0 makes a falling edge on the synchronized pin set that pin's flag, and polarity 1 makes a rising edge set it. The opposite edge does not set the flag. With interrupt enable 0, no edge sets it.
- R7: Edge detection under R6 also works while the pin is configured as an output.
- R8: Flags are sticky. Writing 1 to a bit at offset 6 clears that flag, and writing 0 leaves it unchanged. When a clear and a new edge hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when some pin has both its flag and its interrupt enable set.
- R10: Register offsets are: 0 level, 1 direction, 2 reduced drive, 3 pull enable, 4 polarity, 5 interrupt enable, 6 flags, 7 synchronized pin levels. Offset 7 is read-only, and a write to it has no effect.
- R11: A read returns its data on `bus_rdata` after the clock edge that samples `bus_rd`, and the value holds until the next read. At offset 0, an output pin returns its level bit and an input pin returns its synchronized pad level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| pad_in | input | W | Raw pad input levels |
| pad_oe | output | W | Pad output enable |
| pad_out | output | W | Pad output value |
| pad_rdrv | output | W | Reduced-drive select |
| pad_pu | output | W | Pull-up enable |
| pad_pd | output | W | Pull-down enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with the default width of eight pins and a synchronizer depth of two. At that width, random configuration bytes produce, in one pass, pins that are inputs and pins that are outputs, with every combination of polarity and enables. Random pad bytes then raise rising and falling edges on several pins at once. With the two-stage synchronizer, the cycle in which an edge sets its flag is known. This lets a directed case place a clear write in exactly that cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL  = 3'd0,
        REG_DIR    = 3'd1,
        REG_RDRV   = 3'd2,
        REG_PULLEN = 3'd3,
        REG_POL    = 3'd4,
        REG_IRQEN  = 3'd5,
        REG_FLAG   = 3'd6,
        REG_PIN    = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flag
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    for (genvar g = 0; g < W; g++) begin : g_pin
        logic rise, fall;
        assign rise   = lvl[g] & ~prev_q[g];
        assign fall   = ~lvl[g] & prev_q[g];
        assign hit[g] = ien[g] & (pol[g] ? rise : fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag   <= '0;
        end else begin
            prev_q <= lvl;
            flag   <= (flag & ~clr) | hit;
        end
    end
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rdrv,
    input  logic [W-1:0] pullen,
    input  logic [W-1:0] pol,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] rd_sel,
    output logic [W-1:0] pu,
    output logic [W-1:0] pd
);
    always_comb begin
        oe     = dir;
        out    = dir & level;
        rd_sel = dir & rdrv;
        pu     = ~dir & pullen & ~pol;
        pd     = ~dir & pullen & pol;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_rdrv,
    output logic [W-1:0]      pad_pu,
    output logic [W-1:0]      pad_pd,
    output logic              irq
);
    reg_sel_e     sel;
    logic [W-1:0] level_q, dir_q, rdrv_q, pullen_q, pol_q, ien_q;
    logic [W-1:0] flag_q, pin_sync, clr_mask, rd_mux;

    assign sel = reg_sel_e'(bus_addr);

    gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    assign clr_mask = (bus_wr && sel == REG_FLAG) ? bus_wdata : '0;

    gpio_edge #(.W(W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_sync), .pol(pol_q),
        .ien(ien_q), .clr(clr_mask), .flag(flag_q)
    );

    gpio_padctl #(.W(W)) u_pad (
        .dir(dir_q), .level(level_q), .rdrv(rdrv_q), .pullen(pullen_q),
        .pol(pol_q), .oe(pad_oe), .out(pad_out), .rd_sel(pad_rdrv),
        .pu(pad_pu), .pd(pad_pd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= '0;
            dir_q    <= '0;
            rdrv_q   <= '0;
            pullen_q <= '0;
            pol_q    <= '0;
            ien_q    <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                REG_LEVEL:  level_q  <= bus_wdata;
                REG_DIR:    dir_q    <= bus_wdata;
                REG_RDRV:   rdrv_q   <= bus_wdata;
                REG_PULLEN: pullen_q <= bus_wdata;
                REG_POL:    pol_q    <= bus_wdata;
                REG_IRQEN:  ien_q    <= bus_wdata;
                REG_FLAG, REG_PIN: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_LEVEL:  rd_mux = (dir_q & level_q) | (~dir_q & pin_sync);
            REG_DIR:    rd_mux = dir_q;
            REG_RDRV:   rd_mux = rdrv_q;
            REG_PULLEN: rd_mux = pullen_q;
            REG_POL:    rd_mux = pol_q;
            REG_IRQEN:  rd_mux = ien_q;
            REG_FLAG:   rd_mux = flag_q;
            REG_PIN:    rd_mux = pin_sync;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = |(flag_q & ien_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         bus_rd,
    input logic [2:0]   bus_addr,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_rdrv,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] pad_pd,
    input logic         irq,
    input logic [W-1:0] flag_q,
    input logic [W-1:0] pin_sync
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && !irq && flag_q == '0));

    assert_input_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pad_oe) & (pad_out | pad_rdrv)) == '0);

    assert_pull_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    assert_output_nopull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pu | pad_pd)) == '0);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) & ~flag_q) != '0 |-> $past(bus_wr && bus_addr == 3'd6));

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q != '0);

    assert_pin_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == 3'd7) |-> bus_rdata == $past(pin_sync));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_rdrv(pad_rdrv), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .irq(irq), .flag_q(flag_q), .pin_sync(pin_sync)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int W = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         bus_wr = 0, bus_rd = 0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0, bus_rdata, pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_rdrv, pad_pu, pad_pd;
    logic         irq;

    int total = 0, bad = 0;
    bit done = 0;

    logic [W-1:0] m_lvl, m_dir, m_rdrv, m_pe, m_pol, m_ie, m_flag;

    always #2.5 clk = ~clk;

    gpio_port #(.W(W), .SYNC_DEPTH(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_rdrv(pad_rdrv), .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    function automatic logic [W-1:0] exp_pu();
        return ~m_dir & m_pe & ~m_pol;
    endfunction
    function automatic logic [W-1:0] exp_pd();
        return ~m_dir & m_pe & m_pol;
    endfunction
    function automatic logic [W-1:0] exp_hits(logic [W-1:0] o, logic [W-1:0] n);
        return m_ie & ((m_pol & n & ~o) | (~m_pol & o & ~n));
    endfunction

    task automatic check_pads();
        check("R2/R4 oe", pad_oe, m_dir);
        check("R2/R4 out", pad_out, m_dir & m_lvl);
        check("R2/R5 rdrv", pad_rdrv, m_dir & m_rdrv);
        check("R3/R4 pullup", pad_pu, exp_pu());
        check("R3/R4 pulldown", pad_pd, exp_pd());
    endtask

    task automatic set_reg(int a, logic [W-1:0] d);
        wr(a[2:0], d);
        case (a)
            0: m_lvl = d;
            1: m_dir = d;
            2: m_rdrv = d;
            3: m_pe = d;
            4: m_pol = d;
            5: m_ie = d;
            default: ;
        endcase
    endtask

    task automatic move_pins(logic [W-1:0] n);
        logic [W-1:0] o;
        o = pad_in;
        @(negedge clk);
        pad_in = n;
        repeat (5) @(negedge clk);
        m_flag |= exp_hits(o, n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [W-1:0] d;
        void'($urandom(32'd4242));
        m_lvl = 0; m_dir = 0; m_rdrv = 0; m_pe = 0; m_pol = 0; m_ie = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 oe", pad_oe, '0);
        check("R1 pulls", pad_pu | pad_pd, '0);
        check("R1 irq", {7'd0, irq}, '0);
        rst_n = 1;
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], d);
            check("R1 reg", d, '0);
        end

        // R2 level and reduced drive ignored on inputs
        set_reg(0, 8'hFF); set_reg(2, 8'hFF);
        check("R2 out", pad_out, '0);
        check("R2 rdrv", pad_rdrv, '0);
        // R3 pulls
        set_reg(3, 8'hF0); set_reg(4, 8'hCC);
        check("R3 pu", pad_pu, 8'h30);
        check("R3 pd", pad_pd, 8'hC0);
        // R4 R5 outputs
        set_reg(1, 8'h0F); set_reg(2, 8'h05);
        check_pads();

        // R6 falling edge with pol 0, rising ignored
        set_reg(1, 8'h00); set_reg(4, 8'h00); set_reg(5, 8'h01);
        move_pins(8'h01);
        rd(6, d); check("R6 rise ignored pol0", d, 8'h00);
        move_pins(8'h00);
        rd(6, d); check("R6 fall pol0", d, 8'h01);
        check("R9 irq", {7'd0, irq}, 8'h01);
        // R8 write 0 no effect, write 1 clears
        wr(6, 8'h00); rd(6, d); check("R8 write0", d, 8'h01);
        wr(6, 8'h01); m_flag = 0; rd(6, d); check("R8 clear", d, 8'h00);
        check("R9 irq low", {7'd0, irq}, 8'h00);
        // R7 rising edge in output mode
        set_reg(1, 8'h02); set_reg(4, 8'h02); set_reg(5, 8'h02);
        move_pins(8'h02);
        rd(6, d); check("R7 output-mode edge", d, 8'h02);
        wr(6, 8'hFF); m_flag = 0;
        // R8 set wins over same-cycle clear
        @(negedge clk); pad_in = 8'h00;
        @(negedge clk); pad_in = 8'h02;
        @(negedge clk);
        @(negedge clk); bus_wr = 1; bus_addr = 3'd6; bus_wdata = 8'h02;
        @(negedge clk); bus_wr = 0;
        m_flag = 8'h02;
        rd(6, d); check("R8 set wins", d, 8'h02);
        wr(6, 8'hFF); m_flag = 0;
        // R10 pin view and ignored write
        move_pins(8'hA5);
        wr(7, 8'h00);
        rd(7, d); check("R10 pin view", d, 8'hA5);
        // R11 level read mixes output bits and pins
        rd(0, d); check("R11 level read", d, (m_dir & m_lvl) | (~m_dir & 8'hA5));
        m_flag = 0; wr(6, 8'hFF);

        // random section
        for (int it = 0; it < 150; it++) begin
            int a;
            a = $urandom_range(0, 5);
            set_reg(a, W'($urandom));
            check_pads();
            move_pins(W'($urandom));
            rd(6, d); check("R6 flags", d, m_flag);
            check("R9 irq", {7'd0, irq}, {7'd0, |(m_flag & m_ie)});
            rd(7, d); check("R10 pins", d, pad_in);
            rd(0, d); check("R11 level", d, (m_dir & m_lvl) | (~m_dir & pad_in));
            if ($urandom_range(0, 2) == 0) begin
                logic [W-1:0] mk;
                mk = W'($urandom);
                wr(6, mk);
                m_flag &= ~mk;
            end
        end
        finish_run();
    end
endmodule